// File: doc/BRIEF.md
# Cache Coloring Set-Index Remapper

This block sits in the set-index path of a shared last-level cache. The cache is split into colors. Each color is a run of consecutive sets. For every lookup the block takes a physical address and the requesting core number. It builds the set index from a color chosen by software, followed by the set position inside that color. The color comes from a per-core mapping table. That table is indexed by a region number taken from the low bits of the physical page number. The set position inside the color is taken from the address bits just above the block offset.

Software decides how many colors each core gets, and so sets that core's cache quota in steps of one color. Colors that no core uses can be powered down. A per-color enable mask tells the block which colors are powered. A lookup whose table entry is unmapped, or whose color is powered down, is flagged so that the cache can bypass it. Table entries are written through a simple write port. Lookups have one register stage.

Top module: `ccr_set_remap`

## Requirements
- R1: During reset and in the first cycle after it, `rsp_vld_o` is 0. Reset leaves every table entry unmapped, so a first lookup returns bypass 1 and color field 0.
- R2: A lookup presented with `lkp_vld_i` high in cycle t raises `rsp_vld_o` in cycle t+1. In that cycle `rsp_set_o` = {color[6:0], addr[11:6]}: the color sits in bits 12:6 and the in-color set in bits 5:0.
- R3: The region number is addr[18:12]. It selects an entry in the table that belongs to `lkp_core_i`, and the tables of different cores are independent.
- R4: A write (`cfg_we_i`) stores {`cfg_valid_i`, `cfg_color_i`} at (`cfg_core_i`, `cfg_region_i`). A lookup in the cycle after the write sees the new entry. A lookup in the same cycle as the write sees the old entry.
- R5: A lookup whose entry has valid 0 gives `rsp_bypass_o` = 1, and its color field is forced to 0.
- R6: Bit c of `pwr_mask_i`, sampled in the lookup cycle, enables color c. A mapped lookup whose color bit is 0 gives `rsp_bypass_o` = 1 and still reports the mapped color.
- R7: In the cycle after a cycle with no lookup, `rsp_vld_o` is 0 and `rsp_set_o` and `rsp_bypass_o` keep their previous values.
- R8: Address bits 5:0 and bits 39:19 have no effect on the result.
- R9: The end colors 0 and 127 map exactly. A core can be confined to a range of low colors while the upper colors are off, and then it never raises bypass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lkp_vld_i | input | 1 | Lookup request |
| lkp_addr_i | input | 40 | Physical address of the lookup |
| lkp_core_i | input | 2 | Requesting core |
| cfg_we_i | input | 1 | Table write enable |
| cfg_core_i | input | 2 | Core whose table is written |
| cfg_region_i | input | 7 | Region entry written |
| cfg_color_i | input | 7 | Color stored |
| cfg_valid_i | input | 1 | Mapped flag stored |
| pwr_mask_i | input | 128 | Per-color power enable |
| rsp_vld_o | output | 1 | Result valid, one cycle after lookup |
| rsp_set_o | output | 13 | Remapped set index |
| rsp_bypass_o | output | 1 | Unmapped or powered-off flag |

## Verification
The bench targets a write that lands in the same cycle as a lookup of the same entry. A design that forwards the write, or delays it by a further cycle, returns the wrong color at that point. The end colors 0 and 127 are checked, which exposes a truncated color field or concatenation in the wrong order. Cores share region numbers but hold different colors, so a table indexed without the core gives one core's color to another. Addresses that differ only in block-offset or high bits must give the same set. Mapped entries whose color is masked off must be flagged. A design that tests only the valid bit, or that zeroes the color in that case, fails these checks.

// File: rtl/ccr_pkg.sv
package ccr_pkg;

   // Lookup outcome classes
   typedef enum logic [1:0] {
      CCR_HIT       = 2'd0,
      CCR_UNMAPPED  = 2'd1,
      CCR_POWER_OFF = 2'd2
   } ccr_outcome_e;

   function automatic int ccr_idx_w(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction

endpackage

// File: rtl/ccr_addr_split.sv
module ccr_addr_split #(
   parameter int ADDR_W     = 40,
   parameter int BLK_OFF_W  = 6,
   parameter int PAGE_OFF_W = 12,
   parameter int INCOLOR_W  = 6,
   parameter int REGION_W   = 7
) (
   input  logic [ADDR_W-1:0]    addr_i,
   output logic [REGION_W-1:0]  region_o,
   output logic [INCOLOR_W-1:0] incolor_o
);

   localparam logic [ADDR_W-1:0] INCOLOR_MASK =
      ((ADDR_W'(1) << INCOLOR_W) - ADDR_W'(1)) << BLK_OFF_W;
   localparam logic [ADDR_W-1:0] REGION_MASK  =
      ((ADDR_W'(1) << REGION_W) - ADDR_W'(1)) << PAGE_OFF_W;
   localparam logic [ADDR_W-1:0] USED_MASK    = INCOLOR_MASK | REGION_MASK;

   assign incolor_o = addr_i[BLK_OFF_W +: INCOLOR_W];
   assign region_o  = addr_i[PAGE_OFF_W +: REGION_W];

   // Bits that play no part in the set index
   logic addr_unused_bits;
   assign addr_unused_bits = ^(addr_i & ~USED_MASK);

endmodule

// File: rtl/ccr_map_table.sv
module ccr_map_table #(
   parameter int NUM_CORES   = 4,
   parameter int NUM_REGIONS = 128,
   parameter int COLOR_W     = 7,
   localparam int CORE_W     = ccr_pkg::ccr_idx_w(NUM_CORES),
   localparam int REGION_W   = ccr_pkg::ccr_idx_w(NUM_REGIONS),
   localparam int ENTRY_W    = COLOR_W + 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en_i,
   input  logic [CORE_W-1:0]   wr_core_i,
   input  logic [REGION_W-1:0] wr_region_i,
   input  logic [COLOR_W-1:0]  wr_color_i,
   input  logic                wr_vld_i,
   input  logic [CORE_W-1:0]   rd_core_i,
   input  logic [REGION_W-1:0] rd_region_i,
   output logic [COLOR_W-1:0]  rd_color_o,
   output logic                rd_vld_o
);

   logic [ENTRY_W-1:0] tbl_q [NUM_CORES][NUM_REGIONS];
   logic               wr_core_ok, rd_core_ok;
   logic [ENTRY_W-1:0] rd_entry;

   assign wr_core_ok = ({1'b0, wr_core_i} < (CORE_W+1)'(NUM_CORES));
   assign rd_core_ok = ({1'b0, rd_core_i} < (CORE_W+1)'(NUM_CORES));

   generate
      for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
         for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  tbl_q[c][r] <= '0;
               end else if (wr_en_i && (wr_core_i == CORE_W'(c)) &&
                            (wr_region_i == REGION_W'(r))) begin
                  tbl_q[c][r] <= {wr_vld_i, wr_color_i};
               end
            end
         end
      end
   endgenerate

   always_comb begin
      rd_entry = '0;
      if (rd_core_ok && ({1'b0, rd_region_i} < (REGION_W+1)'(NUM_REGIONS))) begin
         rd_entry = tbl_q[rd_core_i][rd_region_i];
      end
   end

   assign rd_vld_o   = rd_entry[ENTRY_W-1];
   assign rd_color_o = rd_entry[COLOR_W-1:0];

   AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en_i && wr_core_ok) |=>
         (tbl_q[$past(wr_core_i)][$past(wr_region_i)] == $past({wr_vld_i, wr_color_i}))); // R4

endmodule

// File: rtl/ccr_power_check.sv
module ccr_power_check #(
   parameter int NUM_COLORS = 128,
   localparam int COLOR_W   = ccr_pkg::ccr_idx_w(NUM_COLORS)
) (
   input  logic [NUM_COLORS-1:0] mask_i,
   input  logic [COLOR_W-1:0]    color_i,
   input  logic                  mapped_i,
   output ccr_pkg::ccr_outcome_e outcome_o
);

   logic powered;

   generate
      if (NUM_COLORS == (1 << COLOR_W)) begin : g_full
         assign powered = mask_i[color_i];
      end else begin : g_partial
         // Colors past the last one are never powered
         assign powered = ({1'b0, color_i} < (COLOR_W+1)'(NUM_COLORS)) ? mask_i[color_i] : 1'b0;
      end
   endgenerate

   always_comb begin
      if (!mapped_i)     outcome_o = ccr_pkg::CCR_UNMAPPED;
      else if (!powered) outcome_o = ccr_pkg::CCR_POWER_OFF;
      else               outcome_o = ccr_pkg::CCR_HIT;
   end

endmodule

// File: rtl/ccr_set_remap.sv
module ccr_set_remap #(
   parameter int ADDR_W         = 40,
   parameter int BLK_OFF_W      = 6,
   parameter int PAGE_OFF_W     = 12,
   parameter int NUM_CORES      = 4,
   parameter int NUM_COLORS     = 128,
   parameter int SETS_PER_COLOR = 64,
   parameter int NUM_REGIONS    = 128,
   localparam int CORE_W        = ccr_pkg::ccr_idx_w(NUM_CORES),
   localparam int COLOR_W       = ccr_pkg::ccr_idx_w(NUM_COLORS),
   localparam int INCOLOR_W     = ccr_pkg::ccr_idx_w(SETS_PER_COLOR),
   localparam int REGION_W      = ccr_pkg::ccr_idx_w(NUM_REGIONS),
   localparam int SET_W         = COLOR_W + INCOLOR_W
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  lkp_vld_i,
   input  logic [ADDR_W-1:0]     lkp_addr_i,
   input  logic [CORE_W-1:0]     lkp_core_i,
   input  logic                  cfg_we_i,
   input  logic [CORE_W-1:0]     cfg_core_i,
   input  logic [REGION_W-1:0]   cfg_region_i,
   input  logic [COLOR_W-1:0]    cfg_color_i,
   input  logic                  cfg_valid_i,
   input  logic [NUM_COLORS-1:0] pwr_mask_i,
   output logic                  rsp_vld_o,
   output logic [SET_W-1:0]      rsp_set_o,
   output logic                  rsp_bypass_o
);

   // Elaboration-time parameter checks
   generate
      if (BLK_OFF_W + INCOLOR_W > PAGE_OFF_W) begin : g_bad_incolor
         $error("in-color set bits must fit inside the page offset");
      end
      if (PAGE_OFF_W + REGION_W > ADDR_W) begin : g_bad_region
         $error("region bits must fit inside the address");
      end
      if ((1 << INCOLOR_W) != SETS_PER_COLOR) begin : g_bad_spc
         $error("sets per color must be a power of two");
      end
      if (NUM_COLORS < 2 || NUM_CORES < 1 || NUM_REGIONS < 2) begin : g_bad_counts
         $error("color, core or region count out of range");
      end
   endgenerate

   logic [REGION_W-1:0]   region;
   logic [INCOLOR_W-1:0]  incolor;
   logic [COLOR_W-1:0]    tbl_color;
   logic                  tbl_vld;
   logic [COLOR_W-1:0]    color_eff;
   ccr_pkg::ccr_outcome_e outcome;

   ccr_addr_split #(
      .ADDR_W     (ADDR_W),
      .BLK_OFF_W  (BLK_OFF_W),
      .PAGE_OFF_W (PAGE_OFF_W),
      .INCOLOR_W  (INCOLOR_W),
      .REGION_W   (REGION_W)
   ) u_split (
      .addr_i    (lkp_addr_i),
      .region_o  (region),
      .incolor_o (incolor)
   );

   ccr_map_table #(
      .NUM_CORES   (NUM_CORES),
      .NUM_REGIONS (NUM_REGIONS),
      .COLOR_W     (COLOR_W)
   ) u_table (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_en_i     (cfg_we_i),
      .wr_core_i   (cfg_core_i),
      .wr_region_i (cfg_region_i),
      .wr_color_i  (cfg_color_i),
      .wr_vld_i    (cfg_valid_i),
      .rd_core_i   (lkp_core_i),
      .rd_region_i (region),
      .rd_color_o  (tbl_color),
      .rd_vld_o    (tbl_vld)
   );

   ccr_power_check #(
      .NUM_COLORS (NUM_COLORS)
   ) u_power (
      .mask_i    (pwr_mask_i),
      .color_i   (tbl_color),
      .mapped_i  (tbl_vld),
      .outcome_o (outcome)
   );

   assign color_eff = tbl_vld ? tbl_color : '0;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_vld_o    <= 1'b0;
         rsp_set_o    <= '0;
         rsp_bypass_o <= 1'b0;
      end else begin
         rsp_vld_o <= lkp_vld_i;
         if (lkp_vld_i) begin
            rsp_set_o    <= {color_eff, incolor};
            rsp_bypass_o <= (outcome != ccr_pkg::CCR_HIT);
         end
      end
   end

   AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_vld_i |=> rsp_vld_o); // R2

   AST_INCOLOR_PASS: assert property (@(posedge clk) disable iff (!rst_n)
      lkp_vld_i |=> (rsp_set_o[INCOLOR_W-1:0] == $past(lkp_addr_i[BLK_OFF_W +: INCOLOR_W]))); // R2

   AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_vld_i |=> !rsp_vld_o); // R7

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !lkp_vld_i |=> ($stable(rsp_set_o) && $stable(rsp_bypass_o))); // R7

   AST_NO_OFF_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_vld_o && !rsp_bypass_o) |->
         ((($past(pwr_mask_i) >> rsp_set_o[SET_W-1 -: COLOR_W]) & NUM_COLORS'(1)) != '0)); // R6

endmodule

// File: tb/ccr_set_remap_tb.sv
module ccr_set_remap_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         lkp_vld_i = 1'b0;
   logic [39:0]  lkp_addr_i = '0;
   logic [1:0]   lkp_core_i = '0;
   logic         cfg_we_i = 1'b0;
   logic [1:0]   cfg_core_i = '0;
   logic [6:0]   cfg_region_i = '0;
   logic [6:0]   cfg_color_i = '0;
   logic         cfg_valid_i = 1'b0;
   logic [127:0] pwr_mask_i = '1;
   logic         rsp_vld_o;
   logic [12:0]  rsp_set_o;
   logic         rsp_bypass_o;

   int  n_total = 0;
   int  n_fail  = 0;
   bit  done    = 1'b0;

   logic [6:0] ref_color [4][128];
   bit         ref_vld   [4][128];
   logic [12:0] last_set = '0;
   bit          last_byp = 1'b0;

   always #5 clk = ~clk;

   ccr_set_remap dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .lkp_vld_i    (lkp_vld_i),
      .lkp_addr_i   (lkp_addr_i),
      .lkp_core_i   (lkp_core_i),
      .cfg_we_i     (cfg_we_i),
      .cfg_core_i   (cfg_core_i),
      .cfg_region_i (cfg_region_i),
      .cfg_color_i  (cfg_color_i),
      .cfg_valid_i  (cfg_valid_i),
      .pwr_mask_i   (pwr_mask_i),
      .rsp_vld_o    (rsp_vld_o),
      .rsp_set_o    (rsp_set_o),
      .rsp_bypass_o (rsp_bypass_o)
   );

   function automatic logic [39:0] mk_addr(input logic [20:0] hi, input logic [6:0] reg_id,
                                           input logic [5:0] inc, input logic [5:0] blk);
      return {hi, reg_id, inc, blk};
   endfunction

   task automatic chk(input string req, input string what, input logic [31:0] act,
                      input logic [31:0] exp);
      n_total++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // One cycle: drive at a falling edge, check the response at the next one.
   task automatic step(input bit lv, input logic [39:0] addr, input logic [1:0] core,
                       input bit we, input logic [1:0] wcore, input logic [6:0] wreg,
                       input logic [6:0] wcol, input bit wvld, input string req);
      logic [12:0] e_set;
      bit          e_byp;
      logic [6:0]  reg_id;
      logic [6:0]  col;
      reg_id = addr[18:12];
      lkp_vld_i = lv; lkp_addr_i = addr; lkp_core_i = core;
      cfg_we_i = we; cfg_core_i = wcore; cfg_region_i = wreg;
      cfg_color_i = wcol; cfg_valid_i = wvld;
      if (lv) begin
         col   = ref_vld[core][reg_id] ? ref_color[core][reg_id] : 7'd0;
         e_set = {col, addr[11:6]};
         e_byp = !ref_vld[core][reg_id] || !pwr_mask_i[col];
      end else begin
         e_set = last_set;
         e_byp = last_byp;
      end
      if (we) begin
         ref_vld[wcore][wreg]   = wvld;
         ref_color[wcore][wreg] = wcol;
      end
      @(negedge clk);
      chk(req, "rsp_vld_o", 32'(rsp_vld_o), 32'(lv));
      chk(req, "rsp_set_o", 32'(rsp_set_o), 32'(e_set));
      chk(req, "rsp_bypass_o", 32'(rsp_bypass_o), 32'(e_byp));
      last_set = e_set;
      last_byp = e_byp;
   endtask

   task automatic lookup(input logic [39:0] addr, input logic [1:0] core, input string req);
      step(1'b1, addr, core, 1'b0, 2'd0, 7'd0, 7'd0, 1'b0, req);
   endtask

   task automatic wr(input logic [1:0] c, input logic [6:0] r, input logic [6:0] col,
                     input bit v, input string req);
      step(1'b0, '0, 2'd0, 1'b1, c, r, col, v, req);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_total++; n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_total - n_fail, n_total);
         $finish;
      end
   end

   initial begin
      logic [39:0] a;
      void'($urandom(32'd1234));
      for (int c = 0; c < 4; c++)
         for (int r = 0; r < 128; r++) begin
            ref_vld[c][r] = 1'b0; ref_color[c][r] = '0;
         end
      repeat (2) @(negedge clk);
      chk("R1", "rsp_vld_o in reset", 32'(rsp_vld_o), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "rsp_vld_o after reset", 32'(rsp_vld_o), 32'd0);

      // R1 / R5: unmapped after reset
      lookup(mk_addr(21'h0, 7'd5, 6'h2A, 6'h3), 2'd0, "R1");

      // R4: lookup in the write cycle sees the old entry, next cycle the new one
      a = mk_addr(21'h1, 7'd5, 6'h11, 6'h0);
      step(1'b1, a, 2'd0, 1'b1, 2'd0, 7'd5, 7'd127, 1'b1, "R4");
      lookup(a, 2'd0, "R4");
      lookup(mk_addr(21'h1, 7'd5, 6'h3F, 6'h0), 2'd0, "R9");

      // R3 / R9: same region on another core, color 0
      wr(2'd1, 7'd5, 7'd0, 1'b1, "R3");
      lookup(mk_addr(21'h0, 7'd5, 6'h00, 6'h0), 2'd1, "R9");
      lookup(mk_addr(21'h0, 7'd5, 6'h07, 6'h0), 2'd0, "R3");

      // R6: mapped color switched off keeps its color, raises bypass
      pwr_mask_i[127] = 1'b0;
      lookup(mk_addr(21'h0, 7'd5, 6'h09, 6'h0), 2'd0, "R6");
      pwr_mask_i[127] = 1'b1;
      lookup(mk_addr(21'h0, 7'd5, 6'h09, 6'h0), 2'd0, "R6");

      // R7: idle cycles hold the outputs
      step(1'b0, '1, 2'd3, 1'b0, 2'd0, 7'd0, 7'd0, 1'b0, "R7");
      step(1'b0, '0, 2'd0, 1'b0, 2'd0, 7'd0, 7'd0, 1'b0, "R7");

      // R8: block offset and high bits ignored
      lookup(mk_addr(21'h1FFFFF, 7'd5, 6'h15, 6'h3F), 2'd0, "R8");
      lookup(mk_addr(21'h0ABCDE, 7'd5, 6'h15, 6'h00), 2'd0, "R8");

      // R3: region comes from page bits
      wr(2'd2, 7'h55, 7'd3, 1'b1, "R3");
      lookup(mk_addr(21'h0, 7'h55, 6'h01, 6'h0), 2'd2, "R3");
      lookup(mk_addr(21'h0, 7'h54, 6'h01, 6'h0), 2'd2, "R3");

      // R5: entry cleared to unmapped
      wr(2'd2, 7'h55, 7'd3, 1'b0, "R5");
      lookup(mk_addr(21'h0, 7'h55, 6'h01, 6'h0), 2'd2, "R5");

      // R9: core 3 confined to colors 0..15, upper colors off
      for (int r = 0; r < 128; r++) wr(2'd3, 7'(r), 7'(r % 16), 1'b1, "R9");
      pwr_mask_i = 128'hFFFF;
      for (int i = 0; i < 64; i++)
         lookup(40'($urandom()) | (40'($urandom()) << 32), 2'd3, "R9");
      pwr_mask_i = '1;

      // Random mix of lookups and writes
      for (int i = 0; i < 3000; i++) begin
         bit          lv, we;
         logic [39:0] ad;
         if (($urandom() % 16) == 0) pwr_mask_i[$urandom() % 128] = ~pwr_mask_i[$urandom() % 128];
         lv = ($urandom() % 4) != 0;
         we = ($urandom() % 3) == 0;
         ad = {8'($urandom()), 32'($urandom())};
         ad[18:12] = 7'($urandom() % 8);
         step(lv, ad, 2'($urandom()), we, 2'($urandom()), 7'($urandom() % 8),
              7'($urandom()), ($urandom() % 4) != 0, "R2");
      end

      done = 1'b1;
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule